// File: doc/BRIEF.md
# Interrupt Entry and Reset Vector Sequencer

This block takes control of the processor bus whenever the core has to leave reset or divert into an interrupt handler. It holds the pending flags of the two request sources. The non-maskable source outranks the maskable one. At an instruction boundary the block captures the current program bank, program counter, status byte, stack pointer and mode flag from the core. It then runs the fixed series of bus cycles that saves the return context on the stack and fetches the handler address. When the sequence ends it hands the core the new program counter, bank, status, mode and stack pointer, together with a one-cycle completion strobe.

The series of cycles is as follows. First comes a throw-away read at the interrupted address, then a cycle with no bus access. Next come the stack writes. In native mode there are four: the bank byte first, then the high and low program-counter bytes, then the status byte. In emulation mode the bank byte is left out and there are three. Last come two vector reads, low byte first. The vector address depends on both the source and the mode. Leaving reset uses a shorter series that only reads the reset vector. During reset the block also drives the initial values of the other architectural registers. A cold start (power-on) clears the accumulator and the index registers and puts the stack at the top of page one. A warm reset keeps the low bytes.

Top module: `irq_entry_seq`

## Requirements
- R1: When both requests are pending at a boundary, the non-maskable request is serviced, its flag (`nmi_pend`) clears, and `irq_pend` stays 1. A maskable request that is serviced alone clears only `irq_pend`.
- R2: The vectors are read from these addresses. Non-maskable: 0xFFEA in native mode (`cur_e`=0) and 0xFFFA in emulation mode. Maskable: 0xFFEE in native mode and 0xFFFE in emulation mode. All are in bank 0x00, and the second read is at the vector address plus one.
- R3: The first cycle of an entry reads address {`cur_pb`,`cur_pc`}. The next cycle has `bus_valid`=0.
- R4: In native mode the block writes the bank byte, the PC high byte, the PC low byte and the status byte, in that order. In emulation mode the bank-byte write is left out.
- R5: The stacked status byte is `cur_p` with bit 4 forced to 0 in emulation mode. In native mode it is `cur_p` unchanged.
- R6: `done` is 1 in the cycle after the high vector read, and only then. At that point `new_pc` = {high byte, low byte}, `new_pb`=0x00, `new_p` = `cur_p` with bit 2 set and bit 3 cleared, and `new_e` = `cur_e`. An entry takes 8 cycles in native mode and 7 in emulation mode.
- R7: Each stack write goes to bank 0x00 at the current stack pointer, which then decrements. In native mode the decrement is a full 16-bit decrement that wraps from 0x0000 to 0xFFFF. In emulation mode the high byte is held at 0x01 and only the low byte wraps. `new_s` gives the final pointer.
- R8: After `rst_n` is released, the block reads 0xFFFC and then 0xFFFD, and `done` then reports `new_pc` built from those two bytes. During and after reset: `new_p`=0x34, `new_e`=1, `new_pb`=0, `new_d`=0, `new_db`=0.
- R9: Reset with `cold`=1 sets `new_a`, `new_x` and `new_y` to 0 and `new_s` to 0x01FF. Reset with `cold`=0 gives `new_s`={0x01,`cur_s` low byte}, `new_x`/`new_y` = {0x00, low byte of the input}, and `new_a`=`cur_a`.
- R10: An entry starts only when `at_boundary` is 1 while the block is idle. Requests that arrive while the block is busy, or while no boundary is signalled, stay pending and start nothing.
- R11: The block makes at most one access per cycle. Every write goes to bank 0x00, and every read has `bus_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold | input | 1 | Reset is a power-on (cold) reset |
| at_boundary | input | 1 | Core is at an instruction boundary |
| nmi_set | input | 1 | Raise the non-maskable pending flag |
| irq_set | input | 1 | Raise the maskable pending flag |
| cur_e | input | 1 | Current emulation-mode flag |
| cur_pb | input | 8 | Current program bank |
| cur_pc | input | 16 | Current program counter |
| cur_p | input | 8 | Current status byte |
| cur_s | input | 16 | Current stack pointer |
| cur_a | input | 16 | Current accumulator (warm reset) |
| cur_x_lo | input | 8 | Current X low byte (warm reset) |
| cur_y_lo | input | 8 | Current Y low byte (warm reset) |
| bus_valid | output | 1 | Bus access this cycle |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled at the end of the cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe: new_pc updated |
| nmi_pend | output | 1 | Non-maskable request pending |
| irq_pend | output | 1 | Maskable request pending |
| new_pc | output | 16 | Program counter for the core |
| new_pb | output | 8 | Program bank for the core |
| new_p | output | 8 | Status byte for the core |
| new_e | output | 1 | Emulation flag for the core |
| new_s | output | 16 | Stack pointer for the core |
| new_d | output | 16 | Direct page register after reset |
| new_db | output | 8 | Data bank after reset |
| new_a | output | 16 | Accumulator after reset |
| new_x | output | 16 | X register after reset |
| new_y | output | 16 | Y register after reset |

## Verification
Most internal faults are visible at the bus on the very next cycle of an entry, because every cycle has a fixed address, direction and write value. A corrupted stack pointer or mode flag shows up as a wrong write address within one push. A wrong vector selection shows up at the first vector read. A pending flag that is wrongly cleared or kept only becomes visible at `irq_pend`/`nmi_pend` after the completion strobe, or as a missing or extra entry at the next boundary. For that reason the bench reads the flags after every entry. The bench sweeps both modes, each request combination, and stack pointers placed on page and bank wrap edges.

// File: rtl/irqseq_pkg.sv
// Shared state encoding, constants and helpers for the interrupt entry sequencer.
// Assumes an 8-bit data bus, a 24-bit address and bank 0x00 for stack and vectors.
package irqseq_pkg;

    localparam int AW = 24;
    localparam int DW = 8;
    localparam int WW = 16;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RVL, ST_RVH, ST_DUMMY, ST_IO,
        ST_PB, ST_PCH, ST_PCL, ST_PSR, ST_VL, ST_VH
    } seq_state_t;

    localparam logic [WW-1:0] VEC_RESET   = 16'hFFFC;
    localparam logic [WW-1:0] VEC_NMI_NAT = 16'hFFEA;
    localparam logic [WW-1:0] VEC_NMI_EMU = 16'hFFFA;
    localparam logic [WW-1:0] VEC_IRQ_NAT = 16'hFFEE;
    localparam logic [WW-1:0] VEC_IRQ_EMU = 16'hFFFE;

    localparam logic [DW-1:0] P_AFTER_RST = 8'h34;
    localparam logic [DW-1:0] P_BIT4      = 8'h10;
    localparam logic [DW-1:0] P_IMASK     = 8'h04;
    localparam logic [DW-1:0] P_DEC       = 8'h08;
    localparam logic [DW-1:0] STK_PAGE    = 8'h01;
    localparam logic [DW-1:0] BANK0       = 8'h00;

    // Vector address for the serviced source in the captured mode.
    function automatic logic [WW-1:0] vec_addr(input logic is_nmi, input logic emu);
        if (is_nmi) return emu ? VEC_NMI_EMU : VEC_NMI_NAT;
        return emu ? VEC_IRQ_EMU : VEC_IRQ_NAT;
    endfunction

endpackage

// File: rtl/irqseq_arbiter.sv
// Pending-flag holder and priority pick for the two request sources.
// Assumes set pulses may arrive at any time; a set in the same cycle as a
// service of that source wins, so a fresh request is never lost.
module irqseq_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_set,
    input  logic irq_set,
    input  logic take,
    output logic nmi_pend,
    output logic irq_pend,
    output logic req_any,
    output logic grant_nmi
);

    logic nmi_q, irq_q;

    // Hold each flag until the entry that services it begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            nmi_q <= nmi_set | (nmi_q & ~(take & grant_nmi));
            irq_q <= irq_set | (irq_q & ~(take & ~grant_nmi));
        end
    end

    assign grant_nmi = nmi_q;
    assign req_any   = nmi_q | irq_q;
    assign nmi_pend  = nmi_q;
    assign irq_pend  = irq_q;

    // R1: the maskable flag survives an entry that serves the other source.
    p_irq_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && nmi_q && irq_q) |=> irq_q);
    // R1: a serviced non-maskable request is cleared unless re-raised.
    p_nmi_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && nmi_q && !nmi_set) |=> !nmi_q);

endmodule

// File: rtl/irqseq_stack.sv
// Stack pointer register used during entry: loaded at entry start, decremented
// after each push. Assumes emu is stable from load to the last push.
module irqseq_stack
    import irqseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold,
    input  logic [WW-1:0] cur_s,
    input  logic          load,
    input  logic          emu,
    input  logic          dec,
    output logic [WW-1:0] sp
);

    logic [WW-1:0] sp_q;

    // Reset init, capture at entry start, and mode-dependent decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= cold ? {STK_PAGE, 8'hFF} : {STK_PAGE, cur_s[7:0]};
        end else if (load) begin
            sp_q <= emu ? {STK_PAGE, cur_s[7:0]} : cur_s;
        end else if (dec) begin
            sp_q <= emu ? {STK_PAGE, sp_q[7:0] - 8'd1} : sp_q - 16'd1;
        end
    end

    assign sp = sp_q;

    // R7: in emulation mode a push never leaves page one.
    p_emu_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && emu) |=> (sp_q[15:8] == STK_PAGE));
    // R7: in native mode each push steps the full pointer down by one.
    p_nat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !emu && !load) |=> (sp_q == $past(sp_q) - 16'd1));

endmodule

// File: rtl/irqseq_ctrl.sv
// Cycle sequencer: owns the bus during reset-vector fetch and interrupt entry,
// captures the core context at the boundary and produces the hand-over values.
// Assumes bus_rdata is valid at the clock edge that ends a read cycle.
module irqseq_ctrl
    import irqseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold,
    input  logic          at_boundary,
    input  logic          req_any,
    input  logic          grant_nmi,
    input  logic          cur_e,
    input  logic [DW-1:0] cur_pb,
    input  logic [WW-1:0] cur_pc,
    input  logic [DW-1:0] cur_p,
    input  logic [WW-1:0] cur_a,
    input  logic [DW-1:0] cur_x_lo,
    input  logic [DW-1:0] cur_y_lo,
    input  logic [WW-1:0] sp,
    input  logic [DW-1:0] bus_rdata,
    output logic          take,
    output logic          stk_emu,
    output logic          stk_dec,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done,
    output logic [WW-1:0] new_pc,
    output logic [DW-1:0] new_pb,
    output logic [DW-1:0] new_p,
    output logic          new_e,
    output logic [WW-1:0] new_d,
    output logic [DW-1:0] new_db,
    output logic [WW-1:0] new_a,
    output logic [WW-1:0] new_x,
    output logic [WW-1:0] new_y
);

    seq_state_t    state, nxt;
    logic          emu_q;
    logic [DW-1:0] pb_q, p_q, lo_q;
    logic [WW-1:0] pc_q, vec_q;
    logic          acc;

    assign take    = (state == ST_IDLE) && at_boundary && req_any;
    assign stk_emu = take ? cur_e : emu_q;
    assign stk_dec = (state == ST_PB) || (state == ST_PCH) ||
                     (state == ST_PCL) || (state == ST_PSR);
    assign busy    = (state != ST_IDLE);

    // Next-state selection; the bank push is skipped in emulation mode.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (take) nxt = ST_DUMMY;
            ST_RVL:   nxt = ST_RVH;
            ST_RVH:   nxt = ST_IDLE;
            ST_DUMMY: nxt = ST_IO;
            ST_IO:    nxt = emu_q ? ST_PCH : ST_PB;
            ST_PB:    nxt = ST_PCH;
            ST_PCH:   nxt = ST_PCL;
            ST_PCL:   nxt = ST_PSR;
            ST_PSR:   nxt = ST_VL;
            ST_VL:    nxt = ST_VH;
            ST_VH:    nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Bus cycle contents for the current state.
    always_comb begin
        acc       = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            ST_RVL:   bus_addr = {BANK0, VEC_RESET};
            ST_RVH:   bus_addr = {BANK0, VEC_RESET + 16'd1};
            ST_DUMMY: bus_addr = {pb_q, pc_q};
            ST_PB:    begin bus_we = 1'b1; bus_addr = {BANK0, sp}; bus_wdata = pb_q;       end
            ST_PCH:   begin bus_we = 1'b1; bus_addr = {BANK0, sp}; bus_wdata = pc_q[15:8]; end
            ST_PCL:   begin bus_we = 1'b1; bus_addr = {BANK0, sp}; bus_wdata = pc_q[7:0];  end
            ST_PSR:   begin
                bus_we    = 1'b1;
                bus_addr  = {BANK0, sp};
                bus_wdata = emu_q ? (p_q & ~P_BIT4) : p_q;
            end
            ST_VL:    bus_addr = {BANK0, vec_q};
            ST_VH:    bus_addr = {BANK0, vec_q + 16'd1};
            default:  acc = 1'b0;
        endcase
        bus_valid = acc & rst_n;
    end

    // State, context capture, vector byte collection and hand-over registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RVL;
            done   <= 1'b0;
            emu_q  <= 1'b1;
            new_p  <= P_AFTER_RST;
            new_e  <= 1'b1;
            new_pb <= BANK0;
            new_d  <= '0;
            new_db <= BANK0;
            new_a  <= cold ? '0 : cur_a;
            new_x  <= cold ? '0 : {8'h00, cur_x_lo};
            new_y  <= cold ? '0 : {8'h00, cur_y_lo};
        end else begin
            state <= nxt;
            done  <= 1'b0;
            case (state)
                ST_IDLE: if (take) begin
                    pc_q  <= cur_pc;
                    pb_q  <= cur_pb;
                    p_q   <= cur_p;
                    emu_q <= cur_e;
                    vec_q <= vec_addr(grant_nmi, cur_e);
                end
                ST_RVL: lo_q <= bus_rdata;
                ST_RVH: begin
                    new_pc <= {bus_rdata, lo_q};
                    done   <= 1'b1;
                end
                ST_VL: begin
                    lo_q   <= bus_rdata;
                    new_pb <= BANK0;
                    new_p  <= (p_q | P_IMASK) & ~P_DEC;
                    new_e  <= emu_q;
                end
                ST_VH: begin
                    new_pc <= {bus_rdata, lo_q};
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3: the dummy read is always followed by a cycle with no access.
    p_dummy_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |=> !bus_valid);
    // R2: the high vector byte is read from the address after the low one.
    p_vec_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VL) |=> (bus_addr[15:0] == $past(bus_addr[15:0]) + 16'd1));
    // R5: a status push in emulation mode never carries bit 4.
    p_bit4_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && emu_q && (state == ST_PSR)) |-> !bus_wdata[4]);
    // R6: on completion the handler runs in bank 0 with interrupts masked, binary mode.
    p_done_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_p[2] && !new_p[3] && (new_pb == BANK0)));
    // R10: no entry can begin while a sequence is in progress.
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_DUMMY));
    // R11: every write is a valid access into bank 0.
    p_write_bank0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_valid && (bus_addr[23:16] == BANK0)));

endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry / reset vector sequencer: joins the request
// arbiter, the stack pointer and the cycle sequencer. Assumes the core stalls
// while busy is high and takes the new_* values when done pulses.
module irq_entry_seq
    import irqseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold,
    input  logic          at_boundary,
    input  logic          nmi_set,
    input  logic          irq_set,
    input  logic          cur_e,
    input  logic [7:0]    cur_pb,
    input  logic [15:0]   cur_pc,
    input  logic [7:0]    cur_p,
    input  logic [15:0]   cur_s,
    input  logic [15:0]   cur_a,
    input  logic [7:0]    cur_x_lo,
    input  logic [7:0]    cur_y_lo,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [23:0]   bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          nmi_pend,
    output logic          irq_pend,
    output logic [15:0]   new_pc,
    output logic [7:0]    new_pb,
    output logic [7:0]    new_p,
    output logic          new_e,
    output logic [15:0]   new_s,
    output logic [15:0]   new_d,
    output logic [7:0]    new_db,
    output logic [15:0]   new_a,
    output logic [15:0]   new_x,
    output logic [15:0]   new_y
);

    logic          take, req_any, grant_nmi, stk_emu, stk_dec;
    logic [WW-1:0] sp;

    irqseq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .nmi_set(nmi_set), .irq_set(irq_set),
        .take(take), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
        .req_any(req_any), .grant_nmi(grant_nmi)
    );

    irqseq_stack u_stk (
        .clk(clk), .rst_n(rst_n), .cold(cold), .cur_s(cur_s),
        .load(take), .emu(stk_emu), .dec(stk_dec), .sp(sp)
    );

    irqseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cold(cold), .at_boundary(at_boundary),
        .req_any(req_any), .grant_nmi(grant_nmi), .cur_e(cur_e),
        .cur_pb(cur_pb), .cur_pc(cur_pc), .cur_p(cur_p), .cur_a(cur_a),
        .cur_x_lo(cur_x_lo), .cur_y_lo(cur_y_lo), .sp(sp),
        .bus_rdata(bus_rdata), .take(take), .stk_emu(stk_emu),
        .stk_dec(stk_dec), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .done(done), .new_pc(new_pc), .new_pb(new_pb), .new_p(new_p),
        .new_e(new_e), .new_d(new_d), .new_db(new_db), .new_a(new_a),
        .new_x(new_x), .new_y(new_y)
    );

    assign new_s = sp;

endmodule

// File: tb/irq_entry_seq_bench.sv
// Self-checking bench: sweeps modes, request mixes, stack edges and status
// patterns, with every bus cycle predicted from the requirements.
module irq_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n, cold, at_boundary, nmi_set, irq_set, cur_e;
    logic [7:0]  cur_pb, cur_p, cur_x_lo, cur_y_lo;
    logic [15:0] cur_pc, cur_s, cur_a;
    logic        bus_valid, bus_we, busy, done, nmi_pend, irq_pend, new_e;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata, new_pb, new_p, new_db;
    logic [15:0] new_pc, new_s, new_d, new_a, new_x, new_y;

    int n_vec  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    // Memory model: read data is a fixed function of the address.
    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign bus_rdata = memf(bus_addr);

    irq_entry_seq u_irq_entry_seq (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One predicted bus cycle, then advance.
    task automatic cyc(input string req, input logic v, input logic we,
                       input logic [23:0] a, input logic [7:0] wd);
        chk(req, "bus_valid", {31'd0, bus_valid}, {31'd0, v});
        if (v) begin
            chk(req, "bus_we", {31'd0, bus_we}, {31'd0, we});
            chk(req, "bus_addr", {8'd0, bus_addr}, {8'd0, a});
            if (we) chk(req, "bus_wdata", {24'd0, bus_wdata}, {24'd0, wd});
        end
        chk("R6", "done early", {31'd0, done}, 32'd0);
        tick();
    endtask

    function automatic logic [15:0] vexp(input bit nmi, input bit e);
        if (nmi) return e ? 16'hFFFA : 16'hFFEA;
        return e ? 16'hFFFE : 16'hFFEE;
    endfunction

    function automatic logic [15:0] spdec(input logic [15:0] s, input bit e);
        return e ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    endfunction

    // Raise requests, signal a boundary, then check the whole entry.
    task automatic entry(input bit e, input bit nmi, input bit sn, input bit si,
                         input bit inject);
        logic [15:0] sp, va;
        logic [7:0]  pb;
        nmi_set = sn; irq_set = si;
        tick();
        nmi_set = 0; irq_set = 0; at_boundary = 1;
        tick();
        at_boundary = 0;
        sp = e ? {8'h01, cur_s[7:0]} : cur_s;
        pb = cur_pb;
        va = vexp(nmi, e);
        cyc("R3", 1, 0, {cur_pb, cur_pc}, 0);
        if (inject) begin irq_set = 1; at_boundary = 1; end
        cyc("R3", 0, 0, 0, 0);
        irq_set = 0; at_boundary = 0;
        if (!e) begin cyc("R4", 1, 1, {8'h00, sp}, pb); sp = spdec(sp, e); end
        cyc("R7", 1, 1, {8'h00, sp}, cur_pc[15:8]); sp = spdec(sp, e);
        cyc("R4", 1, 1, {8'h00, sp}, cur_pc[7:0]);  sp = spdec(sp, e);
        cyc("R5", 1, 1, {8'h00, sp}, e ? (cur_p & 8'hEF) : cur_p);
        sp = spdec(sp, e);
        cyc("R2", 1, 0, {8'h00, va}, 0);
        cyc("R2", 1, 0, {8'h00, va + 16'd1}, 0);
        chk("R6", "done", {31'd0, done}, 32'd1);
        chk("R6", "new_pc", {16'd0, new_pc},
            {16'd0, memf({8'h00, va + 16'd1}), memf({8'h00, va})});
        chk("R6", "new_pb", {24'd0, new_pb}, 32'd0);
        chk("R6", "new_p", {24'd0, new_p}, {24'd0, (cur_p | 8'h04) & 8'hF7});
        chk("R6", "new_e", {31'd0, new_e}, {31'd0, e});
        chk("R7", "new_s", {16'd0, new_s}, {16'd0, sp});
        chk("R1", "nmi_pend", {31'd0, nmi_pend}, 32'd0);
        tick();
        chk("R6", "done width", {31'd0, done}, 32'd0);
    endtask

    task automatic reset_fetch(input bit cl);
        chk("R8", "bus_valid in reset", {31'd0, bus_valid}, 32'd0);
        chk("R8", "new_p", {24'd0, new_p}, 32'h34);
        chk("R8", "new_e", {31'd0, new_e}, 32'd1);
        chk("R8", "new_pb", {24'd0, new_pb}, 32'd0);
        chk("R8", "new_d", {16'd0, new_d}, 32'd0);
        chk("R8", "new_db", {24'd0, new_db}, 32'd0);
        chk("R9", "new_s", {16'd0, new_s}, cl ? 32'h01FF : {16'd0, 8'h01, cur_s[7:0]});
        chk("R9", "new_a", {16'd0, new_a}, cl ? 32'd0 : {16'd0, cur_a});
        chk("R9", "new_x", {16'd0, new_x}, cl ? 32'd0 : {24'd0, cur_x_lo});
        chk("R9", "new_y", {16'd0, new_y}, cl ? 32'd0 : {24'd0, cur_y_lo});
        rst_n = 1;
        #1;
        cyc("R8", 1, 0, 24'h00FFFC, 0);
        cyc("R8", 1, 0, 24'h00FFFD, 0);
        chk("R8", "done", {31'd0, done}, 32'd1);
        chk("R8", "new_pc", {16'd0, new_pc}, {16'd0, memf(24'hFFFD), memf(24'hFFFC)});
        chk("R8", "busy", {31'd0, busy}, 32'd0);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] svals [4];
        logic [7:0]  pvals [3];
        svals = '{16'h01FF, 16'h0100, 16'h0000, 16'h1234};
        pvals = '{8'hFF, 8'h00, 8'h5A};
        rst_n = 0; cold = 1; at_boundary = 0; nmi_set = 0; irq_set = 0;
        cur_e = 1; cur_pb = 8'h00; cur_pc = 16'h0000; cur_p = 8'h00;
        cur_s = 16'hABCD; cur_a = 16'h1111; cur_x_lo = 8'h22; cur_y_lo = 8'h33;
        tick(); tick();
        reset_fetch(1);

        // R10: a boundary with nothing pending starts nothing.
        at_boundary = 1; tick(); at_boundary = 0;
        chk("R10", "idle boundary", {30'd0, busy, bus_valid}, 32'd0);
        // R10: a request without a boundary stays pending and idle.
        nmi_set = 1; tick(); nmi_set = 0; tick();
        chk("R10", "no boundary", {29'd0, busy, bus_valid, nmi_pend}, 32'd1);
        cur_e = 0; cur_pb = 8'h7E; cur_pc = 16'h8123; cur_p = 8'h3C; cur_s = 16'h1FF0;
        entry(0, 1, 0, 0, 0);

        // Sweep: mode x request mix x stack edge x status pattern.
        for (int e = 0; e < 2; e++)
            for (int k = 0; k < 3; k++)
                for (int si = 0; si < 4; si++)
                    for (int pi = 0; pi < 3; pi++) begin
                        cur_e  = e[0];
                        cur_s  = svals[si];
                        cur_p  = pvals[pi];
                        cur_pb = 8'h40 + 8'(si);
                        cur_pc = 16'h8000 + 16'(si * 16'h0111) + 16'(pi * 7) + 16'(k);
                        entry(e[0], k != 1, k != 1, k != 0, 0);
                        chk("R1", "irq_pend after", {31'd0, irq_pend}, {31'd0, k == 2});
                        if (k == 2) begin
                            entry(e[0], 0, 0, 0, 0);
                            chk("R1", "irq cleared", {31'd0, irq_pend}, 32'd0);
                        end
                    end

        // R10: a request and boundary during an entry are held, not started.
        cur_e = 1; cur_s = 16'h01F0; cur_p = 8'hFF; cur_pb = 8'h00; cur_pc = 16'hC000;
        entry(1, 1, 1, 0, 1);
        chk("R10", "held irq_pend", {31'd0, irq_pend}, 32'd1);
        tick();
        chk("R10", "held no start", {30'd0, busy, bus_valid}, 32'd0);
        entry(1, 0, 0, 0, 0);
        chk("R11", "final irq_pend", {31'd0, irq_pend}, 32'd0);

        // Warm reset keeps low bytes (R9) and refetches the reset vector (R8).
        cur_s = 16'h12AB; cur_a = 16'h5566; cur_x_lo = 8'hEF; cur_y_lo = 8'hFE;
        rst_n = 0; cold = 0; tick(); tick();
        reset_fetch(0);

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule